// File: doc/BRIEF.md
# Strobed Parallel Port with Service Request

This block is a synchronous model of an eight-bit parallel port. It holds a data word in a latch and presents it on an output bus with a separate drive-enable flag that stands in for a three-state pad. It also keeps a service-request flag that drives an active-low interrupt line. Every input is sampled on the rising edge of a system clock `clk`.

Two select inputs form the device select: one is active low and one is active high. A direction input chooses between two modes. In output mode the latch loads when the device is selected, and the bus is always driven. In input mode the latch loads on a strobe, and the bus is driven only while the device is selected.

A falling strobe raises a service request. The interrupt line shows the request only while the device is not selected. An active-low clear empties the latch and withdraws the request.

Top module: `strobed_io_port`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `dout` is 0 and `irq_n` is 1.
- R2: The device select is true exactly when `sel_lo_n` is 0 and `sel_hi` is 1. In input mode (`dir_out`=0), `dout_en` equals the device select in the same cycle.
- R3: In output mode (`dir_out`=1), `dout_en` is 1 in every cycle. At a clock edge where the device select is true, the latch loads `din`, and `dout` shows that value from the next cycle.
- R4: In input mode, at a clock edge where `stb` is 1, the latch loads `din`, and `dout` shows that value from the next cycle.
- R5: At an edge where the latch gate is low and `clr_n` is 1, `dout` keeps its value. The gate is the device select in output mode and `stb` in input mode.
- R6: At an edge where `clr_n` is 0 and the gate is low, `dout` becomes 0 in the next cycle. At an edge where `clr_n` is 0 and the gate is high, the latch loads `din` instead, so an open gate overrides the clear.
- R7: A falling strobe makes a request pending from the next cycle, in either mode. A falling strobe is `stb` at 1 on one edge and at 0 on the next.
- R8: `irq_n` is 0 exactly when a request is pending and the device select is false. Selecting the device brings `irq_n` back to 1 in the same cycle.
- R9: At an edge where `clr_n` is 0, the pending request is withdrawn. This also holds when a falling strobe arrives at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Data presented to the latch |
| sel_lo_n | input | 1 | Device select term, active low |
| sel_hi | input | 1 | Device select term, active high |
| dir_out | input | 1 | Mode: 1 = output mode, 0 = input mode |
| stb | input | 1 | Strobe: latch gate in input mode; its falling edge raises a request |
| clr_n | input | 1 | Clear, active low: empties the latch and withdraws the request |
| dout | output | 8 | Latched data |
| dout_en | output | 1 | High when the data bus would be driven |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench goes after the clear arriving while the gate is open. A design that lets the clear win would show 0 where the new `din` belongs. It also drives the clear and a falling strobe into the same edge. A design with the opposite priority would leave `irq_n` low after the clear. The bench also checks each of the four select combinations in input mode, where a select decoded with the wrong polarity drives the bus at the wrong times. It checks that selecting the device hides a pending request, and that a strobe in output mode still raises one. A design that tied the request to the mode, or latched the select into the interrupt path, would miss one of these cycles.

// File: rtl/strobed_io_port_pkg.sv
package strobed_io_port_pkg;

    typedef enum logic {
        MODE_INPUT  = 1'b0,
        MODE_OUTPUT = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic dev_sel;  // both select terms asserted
        logic gate;     // latch loads at this edge
        logic drive;    // bus driven this cycle
    } port_ctrl_t;

    function automatic logic select_true(input logic lo_n, input logic hi);
        return (!lo_n) && hi;
    endfunction

    function automatic port_ctrl_t decode_ctrl(input logic lo_n, input logic hi,
                                               input port_mode_e mode, input logic strobe);
        port_ctrl_t c;
        c.dev_sel = select_true(lo_n, hi);
        if (mode == MODE_OUTPUT) begin
            c.gate  = c.dev_sel;
            c.drive = 1'b1;
        end else begin
            c.gate  = strobe;
            c.drive = c.dev_sel;
        end
        return c;
    endfunction

endpackage

// File: rtl/port_ctrl_decode.sv
module port_ctrl_decode
    import strobed_io_port_pkg::*;
(
    input  logic       sel_lo_n,
    input  logic       sel_hi,
    input  logic       dir_out,
    input  logic       stb,
    output port_ctrl_t ctrl
);
    port_mode_e mode;

    always_comb begin
        mode = port_mode_e'(dir_out);
        ctrl = decode_ctrl(sel_lo_n, sel_hi, mode, stb);
    end
endmodule

// File: rtl/port_data_latch.sv
module port_data_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] EMPTY = '0;

    logic [WIDTH-1:0] held;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                held[b] <= EMPTY[b];
            end else if (gate) begin
                held[b] <= din[b];          // open gate overrides clear
            end else if (!clr_n) begin
                held[b] <= EMPTY[b];
            end
        end
    end

    assign q = held;
endmodule

// File: rtl/port_service_flag.sv
module port_service_flag (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic clr_n,
    input  logic dev_sel,
    output logic irq_n
);
    logic stb_q;
    logic quiet;     // 1 = no request pending
    logic stb_fall;

    always_ff @(posedge clk) begin
        stb_q <= stb;
    end

    assign stb_fall = stb_q && !stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet <= 1'b1;
        end else if (!clr_n) begin
            quiet <= 1'b1;                  // clear wins over strobe
        end else if (stb_fall) begin
            quiet <= 1'b0;
        end
    end

    assign irq_n = quiet || dev_sel;
endmodule

// File: rtl/strobed_io_port.sv
module strobed_io_port
    import strobed_io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             sel_lo_n,
    input  logic             sel_hi,
    input  logic             dir_out,
    input  logic             stb,
    input  logic             clr_n,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             irq_n
);
    port_ctrl_t ctrl;

    port_ctrl_decode u_dec (
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .dir_out  (dir_out),
        .stb      (stb),
        .ctrl     (ctrl)
    );

    port_data_latch #(.WIDTH(WIDTH)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .gate  (ctrl.gate),
        .clr_n (clr_n),
        .din   (din),
        .q     (dout)
    );

    port_service_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .clr_n   (clr_n),
        .dev_sel (ctrl.dev_sel),
        .irq_n   (irq_n)
    );

    assign dout_en = ctrl.drive;
endmodule

// File: rtl/strobed_io_port_checker.sv
module strobed_io_port_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] din,
    input logic             sel_lo_n,
    input logic             sel_hi,
    input logic             dir_out,
    input logic             stb,
    input logic             clr_n,
    input logic [WIDTH-1:0] dout,
    input logic             dout_en,
    input logic             irq_n
);
    logic selected;
    logic gate_open;
    assign selected  = !sel_lo_n && sel_hi;
    assign gate_open = dir_out ? selected : stb;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (dout == '0) && irq_n);

    assert_input_drive_R2: assert property (@(posedge clk) disable iff (rst)
        !dir_out |-> (dout_en == selected));

    assert_output_drive_R3: assert property (@(posedge clk) disable iff (rst)
        dir_out |-> dout_en);

    assert_output_load_R3: assert property (@(posedge clk) disable iff (rst)
        (dir_out && selected) |=> (dout == $past(din)));

    assert_strobe_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!dir_out && stb) |=> (dout == $past(din)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && clr_n) |=> $stable(dout));

    assert_clear_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (!gate_open && !clr_n) |=> (dout == '0));

    assert_request_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(stb) && clr_n) |=> (irq_n == selected));

    assert_select_masks_R8: assert property (@(posedge clk) disable iff (rst)
        selected |-> irq_n);

    assert_clear_withdraws_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> irq_n);
endmodule

bind strobed_io_port strobed_io_port_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .sel_lo_n (sel_lo_n),
    .sel_hi   (sel_hi),
    .dir_out  (dir_out),
    .stb      (stb),
    .clr_n    (clr_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .irq_n    (irq_n)
);

// File: tb/sim_strobed_io_port.sv
module sim_strobed_io_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] din;
    logic         sel_lo_n, sel_hi, dir_out, stb, clr_n;
    logic [W-1:0] dout;
    logic         dout_en, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench reference state
    logic [W-1:0] m_data;
    logic         m_pending;
    logic         m_stb_prev;
    string        data_tag;

    strobed_io_port #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .din(din), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
        .dir_out(dir_out), .stb(stb), .clr_n(clr_n),
        .dout(dout), .dout_en(dout_en), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic f_sel(input logic lo_n, input logic hi);
        return (lo_n == 1'b0) && (hi == 1'b1);
    endfunction

    function automatic logic f_gate(input logic mode, input logic lo_n,
                                    input logic hi, input logic s);
        return mode ? f_sel(lo_n, hi) : s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational outputs, then advance the model
    task automatic step(input logic [W-1:0] d, input logic lo_n, input logic hi,
                        input logic mode, input logic s, input logic c);
        logic g, fall;
        din = d; sel_lo_n = lo_n; sel_hi = hi; dir_out = mode; stb = s; clr_n = c;
        #1;
        check(mode ? "R3 drive" : "R2 drive", dout_en, mode ? 1'b1 : f_sel(lo_n, hi));
        check(f_sel(lo_n, hi) ? "R8 select masks" : "R7 request", irq_n,
              !(m_pending && !f_sel(lo_n, hi)));
        g = f_gate(mode, lo_n, hi, s);
        fall = m_stb_prev && !s;
        if (g) begin
            m_data = d;
            data_tag = !c ? "R6 override" : (mode ? "R3 load" : "R4 load");
        end else if (!c) begin
            m_data = '0;
            data_tag = "R6 clear";
        end else begin
            data_tag = "R5 hold";
        end
        if (!c) m_pending = 1'b0;
        else if (fall) m_pending = 1'b1;
        m_stb_prev = s;
        @(negedge clk);
        check(data_tag, dout, m_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; din = 8'hA5; sel_lo_n = 1'b1; sel_hi = 1'b0;
        dir_out = 1'b0; stb = 1'b0; clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset dout", dout, 0);
        check("R1 reset irq_n", irq_n, 1);
        rst = 1'b0;
        m_data = '0; m_pending = 1'b0; m_stb_prev = 1'b0;
        @(negedge clk);
        check("R1 after reset dout", dout, 0);
        check("R1 after reset irq_n", irq_n, 1);

        // R2: all select combinations in input mode
        step(8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        step(8'h13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'h14, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        // R4 strobe load, then R7 falling edge with device unselected
        step(8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        step(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);   // R7 irq_n low, R5 hold
        step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);   // R8 select masks request
        // R6 clear empties latch and R9 withdraws request
        step(8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);   // R9 irq_n high
        // R6 override: open gate with clear
        step(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        // R9 clear and falling strobe at the same edge
        step(8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R3 output mode: select loads, strobe ignored as gate, still raises request
        step(8'hC3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        step(8'h99, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);   // R7 fall in output mode
        step(8'h99, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] d;
            logic lo_n, hi, mode, s, c;
            d    = W'($urandom);
            lo_n = ($urandom % 3) != 0;
            hi   = ($urandom % 3) != 0;
            mode = ($urandom % 2) == 1;
            s    = ($urandom % 2) == 1;
            c    = ($urandom % 8) != 0;
            step(d, lo_n, hi, mode, s, c);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule